// File: doc/BRIEF.md
# Staggered Bank Refresh Scheduler

This block issues refresh requests for every bank of one DRAM channel, one bank at a time. Each bank must refresh a row once per refresh period. Instead of refreshing all banks in one burst, the block divides that period by the number of banks in the channel. A countdown runs at the resulting interval, and every time it expires one refresh becomes due. The due refreshes go to the banks in turn, so the refresh load is spread evenly over time.

The command scheduler sees a request with a bank number and a row number. It fits the refresh between normal commands by returning a grant. Each bank keeps its own row counter, so over many periods all rows of every bank are covered. If expiries arrive faster than grants, a small saturating count of owed refreshes is kept.

The control state machine has two states. `IDLE` means no refresh is being offered. `ASK` means a refresh is offered on the ports. The transitions are:
- `due`: `IDLE` to `ASK` when at least one refresh is owed.
- `granted`: `ASK` to `IDLE` when the grant is seen.
- `hold`: each state stays where it is otherwise.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, `ref_req` is 0, `ref_bank` is 0 and `ref_row` is 0.
- R2: The bank count is NBANKS = BANKS_PER_RANK * RANKS_PER_MODULE * MODULES. The expiry interval is INTERVAL = floor(ROW_PERIOD / NBANKS) cycles, or 1 if that is 0. The first `ref_req` is seen after INTERVAL+1 rising edges following reset release. When grants are immediate, successive requests are INTERVAL cycles apart.
- R3: Once `ref_req` is 1, it stays 1 until a grant. While it is 1, `ref_bank` and `ref_row` do not change.
- R4: A grant is taken at a rising edge where both `ref_req` and `ref_gnt` are 1. After a grant, `ref_req` is 0 for at least one cycle.
- R5: Granted refreshes go to the banks in ascending order 0, 1, ..., NBANKS-1, then back to 0.
- R6: Each bank has its own row counter. It starts at 0, increments after that bank is granted, and wraps from ROWS-1 to 0.
- R7: Up to PEND_MAX expiries that are not yet granted are remembered, and each produces one request. Expiries beyond PEND_MAX are dropped.
- R8: `ref_gnt` while `ref_req` is 0 has no effect. It does not change the bank or row, and it does not consume an owed refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Grant from the command scheduler |
| ref_req | output | 1 | Refresh request |
| ref_bank | output | BANK_W | Bank to refresh (flat channel bank index) |
| ref_row | output | ROW_W | Row to refresh in that bank |

## Verification
A wrong countdown value shows up as the first request arriving at the wrong edge. It also shows up as the wrong spacing between grants, visible within one interval. A corrupted bank pointer or row counter shows up at the very next grant, because the bank/row pair no longer follows the round-robin, row-advancing pattern. A wrong owed-refresh count shows up within a few cycles of a long stall: once grants resume, the number of back-to-back requests differs from the saturation limit.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ASK  = 1'b1
    } rf_state_e;

endpackage

// File: rtl/rf_interval_timer.sv
module rf_interval_timer #(
    parameter int INTERVAL = 48,
    localparam int CNT_W   = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (tick) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R2
    reload_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == RELOAD));

    // R2
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rf_pending_ctr.sv
module rf_pending_ctr #(
    parameter int PEND_MAX = 3,
    localparam int PEND_W  = $clog2(PEND_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic any
);
    localparam logic [PEND_W-1:0] TOP = PEND_W'(PEND_MAX);

    logic [PEND_W-1:0] owed_q;
    logic [PEND_W-1:0] owed_d;

    always_comb begin
        owed_d = owed_q;
        unique case ({inc, dec})
            2'b10:   owed_d = (owed_q == TOP) ? owed_q : owed_q + 1'b1;
            2'b01:   owed_d = (owed_q == '0) ? owed_q : owed_q - 1'b1;
            default: owed_d = owed_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else begin
            owed_q <= owed_d;
        end
    end

    assign any = (owed_q != '0);

    // R7
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owed_q == TOP && inc && !dec) |=> (owed_q == TOP));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> any);

endmodule

// File: rtl/rf_row_table.sv
module rf_row_table #(
    parameter int NBANKS = 32,
    parameter int ROWS   = 8192,
    localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [BANK_W-1:0] sel,
    output logic [ROW_W-1:0]  row
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    logic [ROW_W-1:0] rows_q [NBANKS];

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows_q[b] <= '0;
            end else if (adv && sel == BANK_W'(b)) begin
                rows_q[b] <= (rows_q[b] == LAST_ROW) ? '0 : rows_q[b] + 1'b1;
            end
        end
    end

    assign row = rows_q[sel];

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int ROW_PERIOD       = 1560,
    parameter int BANKS_PER_RANK   = 8,
    parameter int RANKS_PER_MODULE = 2,
    parameter int MODULES          = 2,
    parameter int ROWS             = 8192,
    parameter int PEND_MAX         = 3,
    localparam int NBANKS       = BANKS_PER_RANK * RANKS_PER_MODULE * MODULES,
    localparam int INTERVAL_RAW = ROW_PERIOD / NBANKS,
    localparam int INTERVAL     = (INTERVAL_RAW < 1) ? 1 : INTERVAL_RAW,
    localparam int BANK_W       = (NBANKS > 1) ? $clog2(NBANKS) : 1,
    localparam int ROW_W        = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic [BANK_W-1:0] ref_bank,
    output logic [ROW_W-1:0]  ref_row
);
    import refresh_pkg::*;

    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NBANKS - 1);

    rf_state_e         state_q;
    rf_state_e         state_d;
    logic              tick;
    logic              owed;
    logic              taken;
    logic [BANK_W-1:0] bank_q;

    rf_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rf_pending_ctr #(.PEND_MAX(PEND_MAX)) u_owed (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (taken),
        .any   (owed)
    );

    rf_row_table #(.NBANKS(NBANKS), .ROWS(ROWS)) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (taken),
        .sel   (bank_q),
        .row   (ref_row)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: due / granted / hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (owed)    state_d = ST_ASK;
            ST_ASK:  if (ref_gnt) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ref_req = 1'b0;
        unique case (state_q)
            ST_IDLE: ref_req = 1'b0;
            ST_ASK:  ref_req = 1'b1;
            default: ref_req = 1'b0;
        endcase
    end

    assign taken    = ref_req && ref_gnt;
    assign ref_bank = bank_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (taken) begin
            bank_q <= (bank_q == LAST_BANK) ? '0 : bank_q + 1'b1;
        end
    end

    // R3
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt) |=> (ref_req && $stable(ref_bank) && $stable(ref_row)));

    // R4
    drop_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> !ref_req);

    // R5
    round_robin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=>
            (ref_bank == (($past(ref_bank) == LAST_BANK) ? '0 : $past(ref_bank) + 1'b1)));

    // R8
    idle_grant_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_req && ref_gnt) |=> $stable(ref_bank));

endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
    localparam int PERIOD = 68;
    localparam int BPR    = 2;
    localparam int RPM    = 2;
    localparam int MODS   = 2;
    localparam int ROWS   = 4;
    localparam int PMAX   = 3;
    localparam int NB     = BPR * RPM * MODS;
    localparam int IVL    = PERIOD / NB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gnt = 1'b0;
    logic       req;
    logic [2:0] bank;
    logic [1:0] row;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    refresh_sched #(
        .ROW_PERIOD(PERIOD), .BANKS_PER_RANK(BPR), .RANKS_PER_MODULE(RPM),
        .MODULES(MODS), .ROWS(ROWS), .PEND_MAX(PMAX)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt),
        .ref_req(req), .ref_bank(bank), .ref_row(row)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        gnt = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 req in reset", req == 1'b0, req, 0);
        rst_n = 1'b1;
        cyc = 0;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk("R1 req", req == 1'b0, req, 0);
        chk("R1 bank", bank == 3'd0, bank, 0);
        chk("R1 row", row == 2'd0, row, 0);
    endtask

    task automatic t_first_request();
        do_reset();
        wait_cyc(IVL);
        chk("R2 req low before interval", req == 1'b0, req, 0);
        @(negedge clk);
        chk("R2 req at interval+1", req == 1'b1, req, 1);
    endtask

    task automatic t_stall_and_saturate();
        int n = 0;
        bit stable = 1'b1;
        do_reset();
        wait_cyc(IVL + 1);
        while (cyc < 6 * IVL) begin
            if (!(req && bank == 3'd0 && row == 2'd0)) stable = 1'b0;
            @(negedge clk);
        end
        chk("R3 request held and stable while ungranted", stable, stable, 1);
        gnt = 1'b1;
        for (int k = 0; k < IVL; k++) begin
            if (req && gnt) begin
                chk("R7 bank of owed refresh", bank == 3'(n), bank, n);
                n++;
            end
            if (k == IVL - 1) chk("R7 no extra request", req == 1'b0, req, 0);
            @(negedge clk);
        end
        chk("R7 owed refreshes capped", n == PMAX, n, PMAX);
        gnt = 1'b0;
    endtask

    task automatic t_continuous_grant();
        int n = 0;
        int last = 0;
        bit prev = 1'b0;
        do_reset();
        gnt = 1'b1;
        while (n < 5 * NB && cyc < 2000) begin
            if (prev) chk("R4 req drops after grant", req == 1'b0, req, 0);
            prev = 1'b0;
            if (req && gnt) begin
                if (n == 0) chk("R2 first grant edge", cyc == IVL + 1, cyc, IVL + 1);
                else chk("R2 spacing", cyc - last == IVL, cyc - last, IVL);
                chk("R5 R8 bank order", bank == 3'(n % NB), bank, n % NB);
                chk("R6 row advance", row == 2'((n / NB) % ROWS), row, (n / NB) % ROWS);
                last = cyc;
                prev = 1'b1;
                n++;
            end
            @(negedge clk);
        end
        chk("R5 grant count", n == 5 * NB, n, 5 * NB);
        gnt = 1'b0;
    endtask

    initial begin
        t_reset_state();
        t_first_request();
        t_stall_and_saturate();
        t_continuous_grant();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule